// File: doc/BRIEF.md
# Two-Wire Bit-Serial Word Link Node

This node connects a processor to a shared two-wire serial link made of a data wire and a strobe wire. Both wires are open-drain and wired-OR between nodes. A node can only pull a wire low or let it float high. Any number of nodes can hang on the same pair.

By default a node is a passive receiver. Every rising edge seen on the strobe wire moves the current data-wire level into a 16-bit shift register, with no processor involvement. The processor then takes the whole word from `rx_word` in one read.

To send, the processor pulses a load request carrying a word, a field length and a half-period. The node takes control of both wires and shifts out the field least significant bit first, with one strobe pulse per bit. When the last bit has gone out it releases both wires and becomes a receiver again.

Top module: `twl_node`

## Requirements
- R1: After reset, `busy` is 0, `dat_oe` and `strobe_oe` are 0 (both wires released), and `rx_word` is 0.
- R2: While idle, each rising edge of the strobe wire shifts the data-wire level into bit 15 of `rx_word` and moves the old bits one place toward bit 0. After 16 pulses, the first bit received sits in bit 0.
- R3: A partial field of n pulses shifts exactly n times. Changes on the data wire without a strobe rising edge leave `rx_word` unchanged.
- R4: A load request accepted while idle raises `busy` in the next cycle. In that same cycle the strobe wire is driven low, which starts the first low phase.
- R5: The number of strobe pulses equals `load_len`. A length of 0 or any value above 16 sends 16 bits.
- R6: Bits leave least significant first. A 0 drives the data wire low (`dat_oe`=1) and a 1 releases it. The data level is set up at least one clock before each strobe release and does not change during that release.
- R7: Each strobe low phase and each high phase lasts max(`half_cycles`, 2) clocks.
- R8: `busy` stays high for exactly 2·len·half clocks. When it falls, both wires are released together.
- R9: Load requests that arrive while `busy` is high are ignored. They are neither merged into the transfer in progress nor queued.
- R10: The node's own transmitted strobes are not captured: `rx_word` is unchanged by a send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | One-cycle request to send a field |
| load_len | input | 5 | Field length in bits, 1..16 (0 or more than 16 means 16) |
| load_data | input | 16 | Word to send, least significant bit first |
| half_cycles | input | 8 | Clocks per strobe phase, clamped to a minimum of 2 |
| busy | output | 1 | High while the node drives the link |
| rx_word | output | 16 | Received shift register contents |
| dat_in | input | 1 | Level seen on the data wire |
| dat_oe | output | 1 | 1 pulls the data wire low |
| strobe_in | input | 1 | Level seen on the strobe wire |
| strobe_oe | output | 1 | 1 pulls the strobe wire low |

## Verification
The bench wraps the node in a wired-AND line model, so the node's own drive loops back into its receiver.

Several cases are covered, each with the fault it would expose:
- A receiver that did not mask its own strobes, including strobes still in flight through the synchronizer after `busy` drops, would corrupt `rx_word` after a send.
- Off-by-one errors in the phase counter would show up as wrong low or high phase lengths, or a wrong `busy` duration. The short minimum half-period is included for this reason.
- Out-of-range lengths of 0 and 20 expose a design that sends no bits or wraps the count.
- A second request fired mid-transfer exposes a design that restarts or queues the transfer.

// File: rtl/twl_pkg.sv
package twl_pkg;
    localparam int WORD_W   = 16;
    localparam int LEN_W    = $clog2(WORD_W + 1);
    localparam int HALF_W   = 8;
    localparam int MIN_HALF = 2;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_LOW  = 2'd1,
        TX_HIGH = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [LEN_W-1:0]  len;
        logic [HALF_W-1:0] half;
    } tx_job_t;

    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] req);
        if (req == '0 || int'(req) > WORD_W)
            return LEN_W'(WORD_W);
        return req;
    endfunction

    function automatic logic [HALF_W-1:0] eff_half(input logic [HALF_W-1:0] req);
        if (int'(req) < MIN_HALF)
            return HALF_W'(MIN_HALF);
        return req;
    endfunction
endpackage

// File: rtl/twl_sync.sv
module twl_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0] chain [N];

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                chain[i] <= '1;
            else
                chain[i] <= {chain[i][STAGES-2:0], d[i]};
        end
        assign q[i] = chain[i][STAGES-1];
    end
endmodule

// File: rtl/twl_rx.sv
module twl_rx
    import twl_pkg::*;
#(
    parameter int MASK_LAG = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_dat,
    input  logic              s_strobe,
    input  logic              tx_busy,
    output logic [WORD_W-1:0] rx_word
);
    logic              strobe_prev;
    logic [MASK_LAG-1:0] busy_tail;
    logic              rise;
    logic              masked;

    assign rise   = s_strobe & ~strobe_prev;
    assign masked = tx_busy | (|busy_tail);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_prev <= 1'b1;
            busy_tail   <= '0;
            rx_word     <= '0;
        end else begin
            strobe_prev <= s_strobe;
            busy_tail   <= {busy_tail[MASK_LAG-2:0], tx_busy};
            if (rise && !masked)
                rx_word <= {s_dat, rx_word[WORD_W-1:1]};
        end
    end

    // R10
    rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        tx_busy |=> $stable(rx_word));
endmodule

// File: rtl/twl_tx.sv
module twl_tx
    import twl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_req,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [WORD_W-1:0] load_data,
    input  logic [HALF_W-1:0] half_cycles,
    output logic              busy,
    output logic              dat_oe,
    output logic              strobe_oe
);
    localparam logic [HALF_W-1:0] ONE = HALF_W'(1);
    localparam logic [HALF_W-1:0] TWO = HALF_W'(2);

    tx_state_e         st;
    tx_job_t           job;
    logic [HALF_W-1:0] cnt;
    logic              cur_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= TX_IDLE;
            job     <= '0;
            cnt     <= '0;
            cur_bit <= 1'b1;
        end else begin
            case (st)
                TX_IDLE: begin
                    if (load_req) begin
                        job.data <= load_data;
                        job.len  <= eff_len(load_len);
                        job.half <= eff_half(half_cycles);
                        cnt      <= '0;
                        cur_bit  <= 1'b1;
                        st       <= TX_LOW;
                    end
                end
                TX_LOW: begin
                    if (cnt == job.half - TWO)
                        cur_bit <= job.data[0];
                    if (cnt == job.half - ONE) begin
                        cnt <= '0;
                        st  <= TX_HIGH;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                TX_HIGH: begin
                    if (cnt == job.half - ONE) begin
                        cnt <= '0;
                        if (job.len == LEN_W'(1)) begin
                            cur_bit <= 1'b1;
                            st      <= TX_IDLE;
                        end else begin
                            job.len  <= job.len - LEN_W'(1);
                            job.data <= job.data >> 1;
                            st       <= TX_LOW;
                        end
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    assign busy      = (st != TX_IDLE);
    assign strobe_oe = (st == TX_LOW);
    assign dat_oe    = busy & ~cur_bit;

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!strobe_oe && !dat_oe));

    // R6
    data_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_oe) |-> $stable(dat_oe));

    // R4
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> strobe_oe);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && st == TX_LOW && cnt != job.half - ONE) |=> (st == TX_LOW));
endmodule

// File: rtl/twl_node.sv
module twl_node
    import twl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_req,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [WORD_W-1:0] load_data,
    input  logic [HALF_W-1:0] half_cycles,
    output logic              busy,
    output logic [WORD_W-1:0] rx_word,
    input  logic              dat_in,
    output logic              dat_oe,
    input  logic              strobe_in,
    output logic              strobe_oe
);
    localparam int SYNC_STAGES = 2;

    logic [1:0] raw_lines;
    logic [1:0] sync_lines;

    assign raw_lines = {strobe_in, dat_in};

    twl_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    twl_tx u_tx (
        .clk         (clk),
        .rst         (rst),
        .load_req    (load_req),
        .load_len    (load_len),
        .load_data   (load_data),
        .half_cycles (half_cycles),
        .busy        (busy),
        .dat_oe      (dat_oe),
        .strobe_oe   (strobe_oe)
    );

    twl_rx #(.MASK_LAG(SYNC_STAGES + 1)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .s_dat    (sync_lines[0]),
        .s_strobe (sync_lines[1]),
        .tx_busy  (busy),
        .rx_word  (rx_word)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy && rx_word == '0));
endmodule

// File: tb/twl_node_tb.sv
module twl_node_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_req = 1'b0;
    logic [4:0]  load_len = '0;
    logic [15:0] load_data = '0;
    logic [7:0]  half_cycles = 8'd2;
    logic        busy, dat_oe, strobe_oe;
    logic [15:0] rx_word;
    logic        tb_dat_low = 1'b0;
    logic        tb_strobe_low = 1'b0;
    logic        dat_line, strobe_line;

    int errors = 0;
    int checks = 0;
    logic [15:0] exp_rx = '0;

    assign dat_line    = ~(dat_oe | tb_dat_low);
    assign strobe_line = ~(strobe_oe | tb_strobe_low);

    always #5 clk = ~clk;

    twl_node u_dut (
        .clk(clk), .rst(rst), .load_req(load_req), .load_len(load_len),
        .load_data(load_data), .half_cycles(half_cycles), .busy(busy),
        .rx_word(rx_word), .dat_in(dat_line), .dat_oe(dat_oe),
        .strobe_in(strobe_line), .strobe_oe(strobe_oe)
    );

    // data[28:13], len[12:8], half[7:0]
    localparam logic [28:0] VEC [0:4] = '{
        {16'hA5C3, 5'd16, 8'd2},
        {16'h0001, 5'd1,  8'd3},
        {16'h1234, 5'd7,  8'd0},
        {16'hFFFF, 5'd0,  8'd2},
        {16'h8000, 5'd20, 8'd4}
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic send(input logic [15:0] d, input logic [4:0] l, input logic [7:0] h,
                        input bit poke);
        int elen, ehalf, cyc, nb, lowrun, highrun, phase_err;
        logic prevc;
        logic [15:0] got, exp_bits, pre_rx;
        elen  = (l == 0 || l > 16) ? 16 : int'(l);
        ehalf = (h < 2) ? 2 : int'(h);
        pre_rx = rx_word;
        load_data = d; load_len = l; half_cycles = h; load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        // R4: busy and strobe low in first cycle after acceptance
        check(busy && strobe_oe, "R4 start", {busy, strobe_oe}, 2'b11);
        cyc = 0; nb = 0; lowrun = 0; highrun = 0; phase_err = 0; prevc = 1'b0; got = '0;
        while (busy && cyc < 2000) begin
            if (poke && cyc == 3) begin
                load_req = 1'b1; load_data = ~d; load_len = 5'd16; half_cycles = 8'd9;
            end else begin
                load_req = 1'b0;
            end
            if (strobe_oe) begin
                if (!prevc && cyc > 0 && highrun != ehalf) phase_err++;
                lowrun++; highrun = 0;
            end else begin
                if (prevc) begin
                    if (lowrun != ehalf) phase_err++;
                    if (nb < 16) got[nb] = ~dat_oe;
                    nb++;
                end
                highrun++; lowrun = 0;
            end
            prevc = strobe_oe;
            cyc++;
            @(negedge clk);
        end
        load_req = 1'b0;
        if (highrun != ehalf) phase_err++;
        exp_bits = (elen == 16) ? d : (d & ((16'd1 << elen) - 16'd1));
        check(nb == elen, "R5 pulse count", nb, elen);
        check(got == exp_bits, "R6 bit values", got, exp_bits);
        check(phase_err == 0, "R7 phase length", phase_err, 0);
        check(cyc == 2 * elen * ehalf, "R8 busy length", cyc, 2 * elen * ehalf);
        check(!dat_oe && !strobe_oe, "R8 released", {dat_oe, strobe_oe}, 0);
        if (poke) begin
            repeat (2) @(negedge clk);
            check(!busy && !strobe_oe, "R9 not queued", busy, 0);
        end
        repeat (6) @(negedge clk);
        check(rx_word == pre_rx, "R10 own strobes", rx_word, pre_rx);
    endtask

    task automatic drive_rx(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            tb_dat_low = ~bits[i];
            tb_strobe_low = 1'b1;
            repeat (3) @(negedge clk);
            tb_strobe_low = 1'b0;
            repeat (3) @(negedge clk);
            exp_rx = {bits[i], exp_rx[15:1]};
        end
        tb_dat_low = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!busy && !dat_oe && !strobe_oe && rx_word == 0, "R1 reset",
              {busy, dat_oe, strobe_oe, rx_word}, 0);

        for (int v = 0; v < 5; v++)
            send(VEC[v][28:13], VEC[v][12:8], VEC[v][7:0], 1'b0);

        // R9: second request during transfer
        send(16'h0006, 5'd4, 8'd2, 1'b1);

        // R2: full word, first bit ends in bit 0
        drive_rx(16'hC3A5, 16);
        check(rx_word == exp_rx && rx_word == 16'hC3A5, "R2 full word", rx_word, 16'hC3A5);
        drive_rx(16'h5A0F, 16);
        check(rx_word == 16'h5A0F, "R2 second word", rx_word, 16'h5A0F);

        // R3: partial field shifts n times
        drive_rx(16'h0005, 3);
        check(rx_word == exp_rx, "R3 partial", rx_word, exp_rx);

        // R3: data toggling without strobe is ignored
        for (int i = 0; i < 6; i++) begin
            tb_dat_low = ~tb_dat_low;
            repeat (3) @(negedge clk);
        end
        tb_dat_low = 1'b0;
        repeat (6) @(negedge clk);
        check(rx_word == exp_rx, "R3 no strobe", rx_word, exp_rx);

        // R10: send after reception keeps received word
        send(16'h00F0, 5'd8, 8'd2, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule